// File: doc/BRIEF.md
# DMA Page Map Address Translator

This block converts a 22-bit peripheral-bus DMA address into a system memory address. The translation table lives in main memory, and a base register sets where it starts. The bus address is split into a page number and a 9-bit byte offset. The page number selects one 32-bit table entry, and the block reads that entry through a request/acknowledge memory read port.

Bit 31 of the entry marks it as valid, and bits 19:0 hold the physical page frame. The result is the frame followed by the offset. When the lookup fails, the block reports one of two fault classes:

- A master fault means the table entry is not valid.
- A slave fault means the addressed memory does not exist. This happens when the table entry lies beyond memory, or when the translated address does.

The size of the installed memory is an input. The block handles one lookup at a time.

A probe mode exists for debug tools. It performs the same lookup but raises no fault pulses.

Top module: `dma_map_xlat`

## Requirements
- R1: After reset the outputs are as follows: `busy`, `done`, `fetch_req`, `err_master` and `err_slave` are 0, and `base_q` reads 0.
- R2: A write to the base register keeps only bits 28:15 of `base_wdata`, and `base_q` returns that value. Without a write, `base_q` holds its value.
- R3: The table entry address is the base plus ((bus_addr >> 9) × 4 masked with 0x7FFF). When the entry address is below `mem_size`, `fetch_req` rises one cycle after the request is accepted. It stays high with `fetch_addr` stable until a cycle with `fetch_ack`.
- R4: When the entry address is at or above `mem_size`, the block issues no fetch. One cycle after acceptance it pulses `done` with code 2 (slave fault), and a non-probe lookup pulses `err_slave` with `err_page` equal to 0.
- R5: When entry bit 31 is set and the translated address is below `mem_size`, `done` pulses one cycle after the `fetch_ack` cycle. It carries code 0 (success), and `done_pa` equals (entry[19:0] << 9) + bus_addr[8:0].
- R6: When entry bit 31 is clear, `done` carries code 1 (master fault). A non-probe lookup pulses `err_master` with `err_page` equal to bus_addr >> 9.
- R7: When the entry is valid but the translated address is at or above `mem_size`, `done` carries code 2. A non-probe lookup pulses `err_slave` with `err_page` equal to entry[19:0]. A success result always lies below `mem_size`.
- R8: When `req_probe` is high, the lookup gives the same `done` code and `done_pa` as a normal lookup. It never pulses `err_master` or `err_slave`.
- R9: `busy` is high while a fetch is outstanding, and it is low in the cycle `done` pulses. A `req_valid` seen while `busy` is high is ignored and produces no extra `done`.
- R10: `done` lasts one cycle. A fault pulse occurs only together with `done`, and never both kinds at once. A failed lookup returns `done_pa` equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_wr | input | 1 | Write strobe for the table base register |
| base_wdata | input | 32 | Data for the base register |
| base_q | output | 32 | Current table base (bits 28:15 only) |
| mem_size | input | 30 | Installed memory size in bytes; addresses below it exist |
| req_valid | input | 1 | Start a lookup (taken when not busy) |
| req_addr | input | 22 | Bus address to translate |
| req_probe | input | 1 | Probe mode: no fault pulses |
| busy | output | 1 | Entry fetch outstanding |
| fetch_req | output | 1 | Table entry read request |
| fetch_addr | output | 29 | Table entry byte address |
| fetch_ack | input | 1 | Read data valid, ends the request |
| fetch_data | input | 32 | Table entry read data |
| done | output | 1 | One-cycle result pulse |
| done_code | output | 2 | 0 success, 1 master fault, 2 slave fault |
| done_pa | output | 29 | Translated system address (0 on failure) |
| err_master | output | 1 | Master fault pulse |
| err_slave | output | 1 | Slave fault pulse |
| err_page | output | 20 | Page reported with a fault pulse |

## Verification
The embedded assertions check every cycle for these properties:
- the read request stays stable until it is acknowledged;
- fault pulses never occur without `done`, and never occur as a pair;
- probe lookups stay silent;
- `busy` is low at completion;
- a success result always lies inside memory.

Only the bench scenarios can show the translation arithmetic itself. They cover the entry address formed from a known base, the frame-and-offset result, and the fault page reported for each fault kind. They also show the exact boundary where the translated address equals the memory size, that no fetch is issued for an out-of-range table, and that a request arriving mid-fetch leaves no trace.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
  localparam int BUS_AW    = 22;
  localparam int PG_BITS   = 9;
  localparam int PAGE_W    = BUS_AW - PG_BITS;
  localparam int MEM_AW    = 29;
  localparam int FRAME_W   = 20;
  localparam int ENT_W     = 32;
  localparam int VLD_BIT   = 31;
  localparam int SPAN_BITS = 15;
  localparam int BASE_LO   = 15;
  localparam int BASE_HI   = 28;

  typedef enum logic [1:0] {
    XL_OK     = 2'd0,
    XL_MASTER = 2'd1,
    XL_SLAVE  = 2'd2
  } xl_code_t;

  function automatic logic [PAGE_W-1:0] page_of(input logic [BUS_AW-1:0] a);
    return a[BUS_AW-1:PG_BITS];
  endfunction

  function automatic logic [PG_BITS-1:0] offset_of(input logic [BUS_AW-1:0] a);
    return a[PG_BITS-1:0];
  endfunction

  function automatic logic [MEM_AW-1:0] entry_addr(input logic [PAGE_W-1:0] pg,
                                                   input logic [31:0] base);
    logic [MEM_AW-1:0] idx;
    idx = MEM_AW'({pg, 2'b00}) & MEM_AW'((1 << SPAN_BITS) - 1);
    return base[MEM_AW-1:0] + idx;
  endfunction

  function automatic logic [MEM_AW-1:0] phys_addr(input logic [FRAME_W-1:0] fr,
                                                  input logic [PG_BITS-1:0] off);
    return {fr, off};
  endfunction
endpackage

// File: rtl/dmx_base_reg.sv
module dmx_base_reg #(
  parameter int W  = 32,
  parameter int LO = 15,
  parameter int HI = 28
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] KEEP = W'(((64'd1 << (HI + 1)) - 1) & ~((64'd1 << LO) - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (wr) q <= wdata & KEEP;
  end

  assert_base_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(q));
endmodule

// File: rtl/dmx_range_chk.sv
module dmx_range_chk #(
  parameter int AW = 29
) (
  input  logic [AW-1:0] addr,
  input  logic [AW:0]   limit,
  output logic          ok
);
  assign ok = {1'b0, addr} < limit;
endmodule

// File: rtl/dmx_ctrl.sv
module dmx_ctrl
  import dmx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [BUS_AW-1:0]   req_addr,
  input  logic                req_probe,
  input  logic [31:0]         base,
  output logic [MEM_AW-1:0]   ent_addr,
  input  logic                ent_ok,
  output logic                fetch_req,
  output logic [MEM_AW-1:0]   fetch_addr,
  input  logic                fetch_ack,
  input  logic [ENT_W-1:0]    fetch_data,
  output logic [MEM_AW-1:0]   cand_pa,
  input  logic                pa_ok,
  output logic                busy,
  output logic                done,
  output logic [1:0]          done_code,
  output logic [MEM_AW-1:0]   done_pa,
  output logic                err_m,
  output logic                err_s,
  output logic [FRAME_W-1:0]  err_page
);
  typedef enum logic {ST_IDLE, ST_FETCH} st_t;
  st_t                st;
  logic [PAGE_W-1:0]  page_q;
  logic [PG_BITS-1:0] off_q;
  logic               probe_q;
  logic               entry_valid;
  logic [FRAME_W-1:0] entry_frame;

  assign ent_addr    = entry_addr(page_of(req_addr), base);
  assign entry_valid = fetch_data[VLD_BIT];
  assign entry_frame = fetch_data[FRAME_W-1:0];
  assign cand_pa     = phys_addr(entry_frame, off_q);
  assign busy        = (st == ST_FETCH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      page_q     <= '0;
      off_q      <= '0;
      probe_q    <= 1'b0;
      fetch_req  <= 1'b0;
      fetch_addr <= '0;
      done       <= 1'b0;
      done_code  <= XL_OK;
      done_pa    <= '0;
      err_m      <= 1'b0;
      err_s      <= 1'b0;
      err_page   <= '0;
    end else begin
      done  <= 1'b0;
      err_m <= 1'b0;
      err_s <= 1'b0;
      case (st)
        ST_IDLE: if (req_valid) begin
          page_q  <= page_of(req_addr);
          off_q   <= offset_of(req_addr);
          probe_q <= req_probe;
          if (!ent_ok) begin
            done      <= 1'b1;
            done_code <= XL_SLAVE;
            done_pa   <= '0;
            err_s     <= !req_probe;
            err_page  <= '0;
          end else begin
            st         <= ST_FETCH;
            fetch_req  <= 1'b1;
            fetch_addr <= ent_addr;
          end
        end
        ST_FETCH: if (fetch_ack) begin
          st        <= ST_IDLE;
          fetch_req <= 1'b0;
          done      <= 1'b1;
          if (!entry_valid) begin
            done_code <= XL_MASTER;
            done_pa   <= '0;
            err_m     <= !probe_q;
            err_page  <= FRAME_W'(page_q);
          end else if (!pa_ok) begin
            done_code <= XL_SLAVE;
            done_pa   <= '0;
            err_s     <= !probe_q;
            err_page  <= entry_frame;
          end else begin
            done_code <= XL_OK;
            done_pa   <= cand_pa;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_fetch_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && !fetch_ack) |=> (fetch_req && $stable(fetch_addr)));
  assert_probe_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && probe_q) |-> !(err_m || err_s));
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_err_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_m || err_s) |-> done);
  assert_one_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_m && err_s));
endmodule

// File: rtl/dma_map_xlat.sv
module dma_map_xlat
  import dmx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                base_wr,
  input  logic [31:0]         base_wdata,
  output logic [31:0]         base_q,
  input  logic [MEM_AW:0]     mem_size,
  input  logic                req_valid,
  input  logic [BUS_AW-1:0]   req_addr,
  input  logic                req_probe,
  output logic                busy,
  output logic                fetch_req,
  output logic [MEM_AW-1:0]   fetch_addr,
  input  logic                fetch_ack,
  input  logic [ENT_W-1:0]    fetch_data,
  output logic                done,
  output logic [1:0]          done_code,
  output logic [MEM_AW-1:0]   done_pa,
  output logic                err_master,
  output logic                err_slave,
  output logic [FRAME_W-1:0]  err_page
);
  logic [MEM_AW-1:0] ent_addr_w;
  logic [MEM_AW-1:0] cand_pa_w;
  logic              ent_ok_w;
  logic              pa_ok_w;

  dmx_base_reg #(.W(32), .LO(BASE_LO), .HI(BASE_HI)) u_base (
    .clk(clk), .rst_n(rst_n), .wr(base_wr), .wdata(base_wdata), .q(base_q));

  dmx_range_chk #(.AW(MEM_AW)) u_ent_chk (
    .addr(ent_addr_w), .limit(mem_size), .ok(ent_ok_w));

  dmx_range_chk #(.AW(MEM_AW)) u_pa_chk (
    .addr(cand_pa_w), .limit(mem_size), .ok(pa_ok_w));

  dmx_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_addr(req_addr), .req_probe(req_probe),
    .base(base_q), .ent_addr(ent_addr_w), .ent_ok(ent_ok_w),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .fetch_ack(fetch_ack), .fetch_data(fetch_data),
    .cand_pa(cand_pa_w), .pa_ok(pa_ok_w),
    .busy(busy), .done(done), .done_code(done_code), .done_pa(done_pa),
    .err_m(err_master), .err_s(err_slave), .err_page(err_page));

  assert_ok_in_mem_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_code == 2'd0) |-> ({1'b0, done_pa} < mem_size));
endmodule

// File: tb/sim_dma_map_xlat.sv
module sim_dma_map_xlat;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_wr = 1'b0;
  logic [31:0] base_wdata = '0;
  logic [31:0] base_q;
  logic [29:0] mem_size = 30'h0100_0000;
  logic        req_valid = 1'b0;
  logic [21:0] req_addr = '0;
  logic        req_probe = 1'b0;
  logic        busy, fetch_req, done, err_master, err_slave;
  logic [28:0] fetch_addr, done_pa;
  logic        fetch_ack = 1'b0;
  logic [31:0] fetch_data = '0;
  logic [1:0]  done_code;
  logic [19:0] err_page;

  always #10 clk = ~clk;

  dma_map_xlat u0 (.*);

  typedef struct {
    logic [1:0]  code;
    logic [28:0] pa;
    logic        em;
    logic        es;
    logic [19:0] page;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  logic [31:0] mapmem [int unsigned];
  int          total = 0;
  int          bad = 0;
  int          lat = 0;
  int          n_fetch = 0;
  int          n_done = 0;
  int unsigned exp_fetch = 0;
  string       cur_tag = "";
  logic [31:0] base_model = '0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // memory responder
  initial begin
    forever begin
      @(negedge clk);
      if (fetch_req) begin
        n_fetch++;
        chk(fetch_addr == 29'(exp_fetch), cur_tag, "fetch_addr", fetch_addr, exp_fetch);
        repeat (lat) @(negedge clk);
        fetch_ack  = 1'b1;
        fetch_data = mapmem.exists(int'(fetch_addr)) ? mapmem[int'(fetch_addr)] : 32'h0;
        @(negedge clk);
        fetch_ack = 1'b0;
      end
    end
  end

  // monitor
  always @(negedge clk) begin
    if (done) begin
      n_done++;
      if (sb_q.size() == 0) begin
        chk(1'b0, "R9", "unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(done_code == e.code, e.tag, "done_code", done_code, e.code);
        chk(done_pa == e.pa, e.tag, "done_pa", done_pa, e.pa);
        chk(err_master == e.em, e.tag, "err_master", err_master, e.em);
        chk(err_slave == e.es, e.tag, "err_slave", err_slave, e.es);
        if (e.em || e.es)
          chk(err_page == e.page, e.tag, "err_page", err_page, e.page);
        chk(!busy, "R9", "busy at done", busy, 0);
      end
    end else begin
      if (err_master || err_slave) chk(1'b0, "R10", "fault without done", 1, 0);
    end
  end

  task automatic write_base(input logic [31:0] v);
    @(negedge clk);
    base_wr = 1'b1; base_wdata = v;
    @(negedge clk);
    base_wr = 1'b0;
    base_model = v & 32'h1FFF_8000;
  endtask

  task automatic lookup(input logic [21:0] a, input bit probe,
                        input logic [31:0] ent, input int l, input string tag);
    int unsigned ea, pg, off, fr, pa;
    int          f0;
    exp_t        e;
    pg  = int'(a) / 512;
    off = int'(a) % 512;
    ea  = int'(base_model) + ((pg * 4) & 32'h7FFF);
    e.tag = tag; e.pa = '0; e.em = 1'b0; e.es = 1'b0; e.page = '0;
    if (ea >= int'(mem_size)) begin
      e.code = 2'd2; e.es = !probe; e.page = 20'd0;
    end else begin
      mapmem[ea] = ent;
      fr = int'(ent & 32'h000F_FFFF);
      pa = fr * 512 + off;
      if (!ent[31]) begin
        e.code = 2'd1; e.em = !probe; e.page = 20'(pg);
      end else if (pa >= int'(mem_size)) begin
        e.code = 2'd2; e.es = !probe; e.page = 20'(fr);
      end else begin
        e.code = 2'd0; e.pa = 29'(pa);
      end
    end
    exp_fetch = ea; cur_tag = tag; lat = l;
    f0 = n_fetch;
    sb_q.push_back(e);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_probe = probe;
    @(negedge clk);
    req_valid = 1'b0; req_probe = 1'b0;
    while (sb_q.size() != 0) @(negedge clk);
    if (ea >= int'(mem_size))
      chk(n_fetch == f0, "R4", "fetch issued", n_fetch - f0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && fetch_req == 0, "R1", "ctrl outputs", {busy, done, fetch_req}, 0);
    chk(err_master == 0 && err_slave == 0, "R1", "fault outputs", {err_master, err_slave}, 0);
    chk(base_q == 0, "R1", "base_q", base_q, 0);
    rst_n = 1'b1;
    @(negedge clk);

    write_base(32'h8001_8ABC);
    chk(base_q == 32'h0001_8000, "R2", "base mask", base_q, 32'h0001_8000);
    repeat (2) @(negedge clk);
    chk(base_q == 32'h0001_8000, "R2", "base hold", base_q, 32'h0001_8000);

    lookup(22'h000A55, 1'b0, 32'h8000_0123, 0, "R5");
    lookup(22'h3FFFFF, 1'b0, 32'h8000_7FFF, 3, "R5");   // top page, last byte of memory
    lookup(22'h000E10, 1'b0, 32'h0000_0123, 1, "R6");   // invalid entry, page 7
    lookup(22'h001200, 1'b0, 32'h8000_8000, 2, "R7");   // result equals mem_size
    lookup(22'h000E10, 1'b1, 32'h0000_0123, 0, "R8");
    lookup(22'h001200, 1'b1, 32'h8000_8000, 1, "R8");
    lookup(22'h000A55, 1'b1, 32'h8000_0123, 2, "R8");
    lookup(22'h002001, 1'b0, 32'h8000_0040, 0, "R3");

    // request while busy is ignored
    begin
      exp_t e;
      int   d0;
      d0 = n_done;
      mapmem[int'(base_model) + 32'h14] = 32'h8000_0200;
      e.tag = "R9"; e.code = 2'd0; e.pa = 29'(32'h200 * 512 + 3);
      e.em = 1'b0; e.es = 1'b0; e.page = '0;
      exp_fetch = int'(base_model) + 32'h14; cur_tag = "R9"; lat = 6;
      sb_q.push_back(e);
      @(negedge clk);
      req_valid = 1'b1; req_addr = 22'h000A03;
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      chk(busy == 1'b1, "R9", "busy during fetch", busy, 1);
      req_valid = 1'b1; req_addr = 22'h000E10;
      @(negedge clk);
      req_valid = 1'b0;
      while (sb_q.size() != 0) @(negedge clk);
      repeat (10) @(negedge clk);
      chk(n_done - d0 == 1, "R9", "done count", n_done - d0, 1);
    end

    // table beyond memory
    write_base(32'hFFFF_FFFF);
    chk(base_q == 32'h1FFF_8000, "R2", "base mask all ones", base_q, 32'h1FFF_8000);
    lookup(22'h000A55, 1'b0, 32'h8000_0123, 0, "R4");
    lookup(22'h000A55, 1'b1, 32'h8000_0123, 0, "R4");

    repeat (5) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule